// File: doc/BRIEF.md
# Two-Bank SDRAM Command Legality Monitor

This block sits beside the command pins of a synchronous DRAM with two banks. On every rising clock edge it samples clock enable, chip select, the three command strobes, the bank select, the address bit that carries the precharge/auto-precharge flag, and the data mask. It turns the pins into a command and keeps a small state machine per bank. A bank can be idle, open, bursting, bursting with auto-precharge, or recovering from an auto-precharge. Any command that the current bank states forbid is reported one cycle later through an error strobe and a 3-bit error code. A command that is rejected does not change any state.

The block also derives the data-path masks from the data mask pin. Write data is masked on the same edge. The read output is forced to high impedance two edges later. Burst length, full-page bursts, the recovery count after an auto-precharge, the length of the wait after a mode register set and the read mask latency are all parameters.

Top module: `dbk_cmd_guard`

## Requirements
- R1: A command is decoded only when chip select is low and clock enable was high at the previous edge. The strobe levels {ras_n,cas_n,we_n} map as follows: 000 mode set, 001 refresh, 011 activate, 010 precharge, 101 read, 100 write, 110 burst stop, 111 no operation. A deselect, or an edge that follows a clock-enable-low edge, is ignored and changes no state.
- R2: A mode set issued while either bank is not idle reports code 1.
- R3: After an accepted mode set, any command other than no operation at either of the next 2 edges reports code 2. This code takes priority over every other code. No operation inside the window is not an error, and the third edge is free.
- R4: A refresh, whether auto refresh or self-refresh entry (refresh with clock enable low at the same edge), reports code 3 unless both banks are idle.
- R5: For read, write, activate and precharge, ba=0 selects the first bank and ba=1 the second. A precharge with a10=0 closes only the selected bank. A precharge with a10=1 ignores ba and closes both banks.
- R6: While either bank runs a burst with auto-precharge (read or write with a10=1), any read or write reports code 4. A read or write to the other bank is legal from the edge after the last burst beat.
- R7: After an auto-precharged burst whose last beat is at edge e, an activate to that bank before edge e+TRP_CYC reports code 7. An activate at edge e+TRP_CYC or later is legal.
- R8: A read or write to a bank that is not open reports code 5. An activate to a bank that is open or bursting reports code 6.
- R9: A burst covers BURST_LEN edges, counting the read or write edge as the first. A full-page burst has no end of its own. A burst stop is legal at any burst length and ends the burst at its own edge.
- R10: wr_en is the inverse of dqm on the same cycle. rd_oe is low for exactly the cycle in which the edge two edges after the edge that sampled dqm high is awaited. This is read mask latency 2.
- R11: err_strobe is high, and err_code holds the code, for the one cycle after the offending edge. Otherwise err_strobe is low and err_code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 1 | Bank select |
| a10 | input | 1 | All-bank / auto-precharge flag |
| dqm | input | 1 | Data mask pin |
| err_strobe | output | 1 | One-cycle pulse for an illegal command |
| err_code | output | 3 | Reason for the illegal command, 0 when none |
| wr_en | output | 1 | Write data enable, same cycle as dqm |
| rd_oe | output | 1 | Read output enable, dqm delayed by the read mask latency |

## Verification
The assertions watch, on every cycle, that a refresh with a bank not idle, a read or write during an auto-precharged burst, a non-idle command in the mode-set window and an activate to an open bank are all reported with the right code. They also check that an all-bank precharge leaves no bank open, and that rd_oe follows dqm two edges late. Some behaviours appear only in the bench's directed sequences: the exact edge at which a burst ends, and the edge at which the recovery count lets an activate through. The same holds for a burst stop cutting an auto-precharged burst, for commands ignored when clock enable was low or chip select high, and for a rejected command leaving the bank states untouched.

// File: rtl/dbk_pkg.sv
package dbk_pkg;
  localparam int NBANK = 2;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_MRS, CMD_REF, CMD_ACT, CMD_PRE, CMD_RD, CMD_WR, CMD_BST
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE, BK_ACT, BK_BURST, BK_BURST_AP, BK_RECOVER
  } bank_state_e;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_MRS_BUSY  = 3'd1,
    ERR_MRS_GAP   = 3'd2,
    ERR_REF_BUSY  = 3'd3,
    ERR_AP_LOCK   = 3'd4,
    ERR_BANK_IDLE = 3'd5,
    ERR_BANK_OPEN = 3'd6,
    ERR_TRP       = 3'd7
  } err_e;
endpackage

// File: rtl/dbk_cmd_decode.sv
module dbk_cmd_decode
  import dbk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  logic cke_q;
  logic cke_d;

  assign cke_d = cke;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke_d;
  end

  // R1: decode only with chip select low and clock enable high one edge back
  always_comb begin
    cmd = CMD_NOP;
    if (cke_q && !cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = CMD_REF;
        3'b011:  cmd = CMD_ACT;
        3'b010:  cmd = CMD_PRE;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/dbk_bank_fsm.sv
module dbk_bank_fsm
  import dbk_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter bit FULL_PAGE = 1'b0,
  parameter int TRP_CYC   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go_act,
  input  logic        go_rw,
  input  logic        rw_ap,
  input  logic        go_pre,
  input  logic        go_stop,
  input  logic        go_cut,
  output bank_state_e state
);
  localparam int CNT_W = $clog2(BURST_LEN + TRP_CYC + 1) + 1;
  localparam logic [CNT_W-1:0] BL_LOAD  = CNT_W'(BURST_LEN - 1);
  localparam logic [CNT_W-1:0] TRP_LOAD = CNT_W'(TRP_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam bit ONE_BEAT = (BURST_LEN == 1) && !FULL_PAGE;

  bank_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             finish, fin_ap;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    finish  = 1'b0;
    fin_ap  = 1'b0;
    if (go_act) begin
      state_d = BK_ACT;
    end else if (go_rw) begin
      // R9: the command edge is the first beat
      if (ONE_BEAT) begin
        finish = 1'b1;
        fin_ap = rw_ap;
      end else begin
        state_d = rw_ap ? BK_BURST_AP : BK_BURST;
        cnt_d   = BL_LOAD;
      end
    end else if (go_pre) begin
      if (state_q == BK_ACT || state_q == BK_BURST) state_d = BK_IDLE;
    end else if ((go_stop || go_cut) && state_q == BK_BURST) begin
      state_d = BK_ACT;
    end else if (go_stop && state_q == BK_BURST_AP) begin
      finish = 1'b1;
      fin_ap = 1'b1;
    end else begin
      case (state_q)
        BK_BURST, BK_BURST_AP: begin
          if (!FULL_PAGE) begin
            if (cnt_q <= CNT_ONE) begin
              finish = 1'b1;
              fin_ap = (state_q == BK_BURST_AP);
            end else begin
              cnt_d = cnt_q - CNT_ONE;
            end
          end
        end
        BK_RECOVER: begin
          if (cnt_q <= CNT_ONE) state_d = BK_IDLE;
          else                  cnt_d   = cnt_q - CNT_ONE;
        end
        default: ;
      endcase
    end
    // R7: auto-precharge recovery begins at the last beat
    if (finish) begin
      if (!fin_ap)           state_d = BK_ACT;
      else if (TRP_CYC <= 1) state_d = BK_IDLE;
      else begin
        state_d = BK_RECOVER;
        cnt_d   = TRP_LOAD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BK_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/dbk_dqm_path.sv
module dbk_dqm_path #(
  parameter int RD_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dqm,
  output logic wr_en,
  output logic rd_oe
);
  logic [RD_LAT-1:0] pipe_q, pipe_d;

  generate
    if (RD_LAT == 1) begin : g_short
      assign pipe_d = dqm;
    end else begin : g_long
      assign pipe_d = {pipe_q[RD_LAT-2:0], dqm};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_d;
  end

  // R10: write mask acts at once, read mask after RD_LAT edges
  assign wr_en = !dqm;
  assign rd_oe = !pipe_q[RD_LAT-1];
endmodule

// File: rtl/dbk_cmd_guard.sv
module dbk_cmd_guard
  import dbk_pkg::*;
#(
  parameter int BURST_LEN   = 4,
  parameter bit FULL_PAGE   = 1'b0,
  parameter int TRP_CYC     = 3,
  parameter int MRS_GAP     = 2,
  parameter int RD_MASK_LAT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       ba,
  input  logic       a10,
  input  logic       dqm,
  output logic       err_strobe,
  output logic [2:0] err_code,
  output logic       wr_en,
  output logic       rd_oe
);
  localparam int GAP_W = $clog2(MRS_GAP + 1) + 1;
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(MRS_GAP);

  cmd_e                     cmd;
  bank_state_e [NBANK-1:0]  bank_st;
  logic [NBANK-1:0]         go_act, go_rw, go_pre, go_cut;
  logic                     go_stop;
  logic [GAP_W-1:0]         gap_q, gap_d;
  logic                     mrs_wait;
  logic                     all_idle, any_ap, accept;
  bank_state_e              sel_st;
  err_e                     err_d;
  logic                     strobe_q;
  err_e                     code_q;

  dbk_cmd_decode u_decode (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  assign mrs_wait = (gap_q != '0);
  assign sel_st   = bank_st[ba];

  always_comb begin
    all_idle = 1'b1;
    any_ap   = 1'b0;
    for (int i = 0; i < NBANK; i++) begin
      if (bank_st[i] != BK_IDLE)    all_idle = 1'b0;
      if (bank_st[i] == BK_BURST_AP) any_ap  = 1'b1;
    end
  end

  // Legality: R2, R3, R4, R6, R7, R8
  always_comb begin
    err_d = ERR_NONE;
    if (cmd != CMD_NOP && mrs_wait) begin
      err_d = ERR_MRS_GAP;
    end else begin
      case (cmd)
        CMD_MRS: if (!all_idle) err_d = ERR_MRS_BUSY;
        CMD_REF: if (!all_idle) err_d = ERR_REF_BUSY;
        CMD_ACT: begin
          if (sel_st == BK_RECOVER)   err_d = ERR_TRP;
          else if (sel_st != BK_IDLE) err_d = ERR_BANK_OPEN;
        end
        CMD_RD, CMD_WR: begin
          if (any_ap) err_d = ERR_AP_LOCK;
          else if (sel_st != BK_ACT && sel_st != BK_BURST) err_d = ERR_BANK_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign accept  = (cmd != CMD_NOP) && (err_d == ERR_NONE);
  assign go_stop = accept && (cmd == CMD_BST);

  // R5: bank steering, a10 widens precharge to every bank
  generate
    for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
      localparam bit BID = (gi != 0);
      logic is_rw;
      assign is_rw      = (cmd == CMD_RD) || (cmd == CMD_WR);
      assign go_act[gi] = accept && (cmd == CMD_ACT) && (ba == BID);
      assign go_rw[gi]  = accept && is_rw && (ba == BID);
      assign go_cut[gi] = accept && is_rw && (ba != BID);
      assign go_pre[gi] = accept && (cmd == CMD_PRE) && (a10 || (ba == BID));

      dbk_bank_fsm #(
        .BURST_LEN(BURST_LEN), .FULL_PAGE(FULL_PAGE), .TRP_CYC(TRP_CYC)
      ) u_bank (
        .clk(clk), .rst_n(rst_n), .go_act(go_act[gi]), .go_rw(go_rw[gi]),
        .rw_ap(a10), .go_pre(go_pre[gi]), .go_stop(go_stop),
        .go_cut(go_cut[gi]), .state(bank_st[gi])
      );
    end
  endgenerate

  // R3: wait window after an accepted mode set
  always_comb begin
    gap_d = gap_q;
    if (accept && cmd == CMD_MRS) gap_d = GAP_LOAD;
    else if (mrs_wait)            gap_d = gap_q - GAP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q    <= '0;
      strobe_q <= 1'b0;
      code_q   <= ERR_NONE;
    end else begin
      gap_q    <= gap_d;
      strobe_q <= (err_d != ERR_NONE);
      code_q   <= err_d;
    end
  end

  // R11: registered report
  assign err_strobe = strobe_q;
  assign err_code   = code_q;

  dbk_dqm_path #(.RD_LAT(RD_MASK_LAT)) u_dqm (
    .clk(clk), .rst_n(rst_n), .dqm(dqm), .wr_en(wr_en), .rd_oe(rd_oe)
  );
endmodule

// File: rtl/dbk_guard_chk.sv
module dbk_guard_chk
  import dbk_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke,
  input  logic                    cs_n,
  input  logic                    ras_n,
  input  logic                    cas_n,
  input  logic                    we_n,
  input  logic                    ba,
  input  logic                    a10,
  input  logic                    dqm,
  input  logic                    err_strobe,
  input  logic [2:0]              err_code,
  input  logic                    rd_oe,
  input  bank_state_e [NBANK-1:0] bank_st,
  input  logic                    mrs_wait
);
  logic       ck_prev;
  logic [1:0] warm;
  logic       live;
  logic [2:0] rcw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_prev <= 1'b0;
      warm    <= 2'd0;
    end else begin
      ck_prev <= cke;
      if (warm != 2'd2) warm <= warm + 2'd1;
    end
  end

  assign live = ck_prev && !cs_n;
  assign rcw  = {ras_n, cas_n, we_n};

  p_refresh_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && rcw == 3'b001 && !mrs_wait &&
     (bank_st[0] != BK_IDLE || bank_st[1] != BK_IDLE))
    |=> (err_strobe && err_code == 3'd3));

  p_ap_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && (rcw == 3'b101 || rcw == 3'b100) && !mrs_wait &&
     (bank_st[0] == BK_BURST_AP || bank_st[1] == BK_BURST_AP))
    |=> (err_code == 3'd4));

  p_all_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && rcw == 3'b010 && a10 && !mrs_wait)
    |=> (bank_st[0] != BK_ACT && bank_st[0] != BK_BURST &&
         bank_st[1] != BK_ACT && bank_st[1] != BK_BURST));

  p_mrs_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && rcw != 3'b111 && mrs_wait) |=> (err_code == 3'd2));

  p_act_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (live && rcw == 3'b011 && !mrs_wait && bank_st[ba] == BK_ACT)
    |=> (err_code == 3'd6));

  p_rd_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (rd_oe == !$past(dqm, 2)));
endmodule

bind dbk_cmd_guard dbk_guard_chk u_guard_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .dqm(dqm),
  .err_strobe(err_strobe), .err_code(err_code), .rd_oe(rd_oe),
  .bank_st(bank_st), .mrs_wait(mrs_wait)
);

// File: tb/dbk_cmd_guard_bench.sv
`timescale 1ns/1ps
module dbk_cmd_guard_bench;
  localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_ACT = 3'b011,
                         C_PRE = 3'b010, C_RD  = 3'b101, C_WR  = 3'b100,
                         C_BST = 3'b110, C_NOP = 3'b111;

  logic clk = 1'b0;
  logic rst_n, cke, cs_n, ras_n, cas_n, we_n, ba, a10, dqm;
  logic err_strobe, wr_en, rd_oe;
  logic [2:0] err_code;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dbk_cmd_guard u_dbk_cmd_guard (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .dqm(dqm),
    .err_strobe(err_strobe), .err_code(err_code), .wr_en(wr_en), .rd_oe(rd_oe)
  );

  task automatic check_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check_code(input logic [2:0] exp, input string tag);
    checks++;
    if (err_code !== exp || err_strobe !== (exp != 3'd0)) begin
      errors++;
      $display("FAIL %s: code=%0d strobe=%0b expected code=%0d strobe=%0b",
               tag, err_code, err_strobe, exp, (exp != 3'd0));
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic issue(input logic [2:0] rcw, input logic b, input logic ap,
                       input logic csn, input logic ck, input logic dm);
    {ras_n, cas_n, we_n} = rcw;
    ba = b; a10 = ap; cs_n = csn; cke = ck; dqm = dm;
    @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] rcw, input logic b, input logic ap,
                     input logic [2:0] exp, input string tag);
    issue(rcw, b, ap, 1'b0, 1'b1, 1'b0);
    check_code(exp, tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    issue(C_NOP, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    issue(C_NOP, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    check_code(3'd0, "R11 reset");
    check_bit(rd_oe, 1'b0, "R10 reset rd_oe");
    check_bit(wr_en, 1'b0, "R10 reset wr_en");
    rst_n = 1'b1;
    issue(C_NOP, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    issue(C_NOP, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    check_bit(rd_oe, 1'b1, "R10 rd_oe after reset");
  endtask

  task automatic t_r1_gating;
    issue(C_NOP, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    issue(C_ACT, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check_code(3'd0, "R1 act after cke low");
    cmd(C_RD, 1'b0, 1'b0, 3'd5, "R1 act after cke low ignored");
    issue(C_ACT, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    check_code(3'd0, "R1 deselect");
    cmd(C_RD, 1'b0, 1'b0, 3'd5, "R1 deselect ignored");
  endtask

  task automatic t_r8_bank;
    cmd(C_ACT, 1'b0, 1'b0, 3'd0, "R8 act A");
    cmd(C_ACT, 1'b0, 1'b0, 3'd6, "R8 act open A");
    cmd(C_RD,  1'b1, 1'b0, 3'd5, "R8 read idle B");
    cmd(C_WR,  1'b0, 1'b0, 3'd0, "R8 write open A");
    cmd(C_PRE, 1'b0, 1'b0, 3'd0, "R8 precharge A");
    cmd(C_RD,  1'b0, 1'b0, 3'd5, "R8 read closed A");
    cmd(C_NOP, 1'b0, 1'b0, 3'd0, "R11 strobe clears");
  endtask

  task automatic t_mrs;
    cmd(C_ACT, 1'b0, 1'b0, 3'd0, "R2 act A");
    cmd(C_MRS, 1'b0, 1'b0, 3'd1, "R2 mode set with open bank");
    cmd(C_PRE, 1'b0, 1'b1, 3'd0, "R2 precharge all");
    cmd(C_MRS, 1'b0, 1'b0, 3'd0, "R2 mode set idle");
    cmd(C_ACT, 1'b1, 1'b0, 3'd2, "R3 gap edge 1");
    cmd(C_ACT, 1'b1, 1'b0, 3'd2, "R3 gap edge 2");
    cmd(C_ACT, 1'b1, 1'b0, 3'd0, "R3 gap over");
    cmd(C_PRE, 1'b0, 1'b1, 3'd0, "R3 precharge all");
    cmd(C_MRS, 1'b0, 1'b0, 3'd0, "R3 mode set again");
    cmd(C_NOP, 1'b0, 1'b0, 3'd0, "R3 nop in gap");
    cmd(C_NOP, 1'b0, 1'b0, 3'd0, "R3 nop in gap 2");
    cmd(C_REF, 1'b0, 1'b0, 3'd0, "R3 refresh after gap");
  endtask

  task automatic t_r4_refresh;
    cmd(C_ACT, 1'b1, 1'b0, 3'd0, "R4 act B");
    cmd(C_REF, 1'b0, 1'b0, 3'd3, "R4 refresh busy");
    issue(C_REF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check_code(3'd3, "R4 self refresh busy");
    issue(C_NOP, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check_code(3'd0, "R4 wake");
    cmd(C_PRE, 1'b0, 1'b1, 3'd0, "R4 precharge all");
    cmd(C_REF, 1'b0, 1'b0, 3'd0, "R4 refresh idle");
    issue(C_REF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check_code(3'd0, "R4 self refresh idle");
    issue(C_NOP, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check_code(3'd0, "R4 exit");
  endtask

  task automatic t_r5_select;
    cmd(C_ACT, 1'b0, 1'b0, 3'd0, "R5 act A");
    cmd(C_ACT, 1'b1, 1'b0, 3'd0, "R5 act B");
    cmd(C_PRE, 1'b1, 1'b0, 3'd0, "R5 precharge B only");
    cmd(C_ACT, 1'b0, 1'b0, 3'd6, "R5 A still open");
    cmd(C_ACT, 1'b1, 1'b0, 3'd0, "R5 B was closed");
    cmd(C_PRE, 1'b0, 1'b1, 3'd0, "R5 precharge all ignores ba");
    cmd(C_RD,  1'b0, 1'b0, 3'd5, "R5 A closed by all");
    cmd(C_RD,  1'b1, 1'b0, 3'd5, "R5 B closed by all");
  endtask

  task automatic t_autopre;
    cmd(C_ACT, 1'b0, 1'b0, 3'd0, "R6 act A");
    cmd(C_ACT, 1'b1, 1'b0, 3'd0, "R6 act B");
    cmd(C_RD,  1'b0, 1'b1, 3'd0, "R6 read A auto-precharge");
    cmd(C_RD,  1'b1, 1'b0, 3'd4, "R6 lock beat 2");
    cmd(C_WR,  1'b1, 1'b0, 3'd4, "R6 lock beat 3");
    cmd(C_RD,  1'b1, 1'b0, 3'd4, "R9 lock last beat");
    cmd(C_RD,  1'b1, 1'b0, 3'd0, "R9 burst over, other bank");
    cmd(C_ACT, 1'b0, 1'b0, 3'd7, "R7 act too early");
    cmd(C_ACT, 1'b0, 1'b0, 3'd0, "R7 act at recovery end");
    cmd(C_PRE, 1'b0, 1'b1, 3'd0, "R6 precharge all");
  endtask

  task automatic t_r9_stop;
    cmd(C_BST, 1'b0, 1'b0, 3'd0, "R9 stop with no burst");
    cmd(C_ACT, 1'b0, 1'b0, 3'd0, "R9 act A");
    cmd(C_ACT, 1'b1, 1'b0, 3'd0, "R9 act B");
    cmd(C_WR,  1'b0, 1'b1, 3'd0, "R9 write A auto-precharge");
    cmd(C_BST, 1'b0, 1'b0, 3'd0, "R9 burst stop");
    cmd(C_RD,  1'b1, 1'b0, 3'd0, "R9 lock released by stop");
    cmd(C_ACT, 1'b0, 1'b0, 3'd7, "R7 recovery after stop");
    cmd(C_ACT, 1'b0, 1'b0, 3'd0, "R7 act after stop recovery");
    cmd(C_PRE, 1'b0, 1'b1, 3'd0, "R9 precharge all");
  endtask

  task automatic t_r10_mask;
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; cs_n = 1'b1; cke = 1'b1;
    dqm = 1'b1;
    #1 check_bit(wr_en, 1'b0, "R10 write mask same cycle");
    @(negedge clk);
    check_bit(rd_oe, 1'b1, "R10 read not yet masked");
    dqm = 1'b0;
    #1 check_bit(wr_en, 1'b1, "R10 write enable same cycle");
    @(negedge clk);
    check_bit(rd_oe, 1'b0, "R10 read masked two edges on");
    @(negedge clk);
    check_bit(rd_oe, 1'b1, "R10 read mask one cycle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1;
    we_n = 1'b1; ba = 1'b0; a10 = 1'b0; dqm = 1'b1;
    @(negedge clk);
    t_reset();
    t_r1_gating();
    t_r8_bank();
    t_mrs();
    t_r4_refresh();
    t_r5_select();
    t_autopre();
    t_r9_stop();
    t_r10_mask();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule